// File: doc/BRIEF.md
# Dual-Address Transfer Engine

The engine copies data from a source address to a destination address, one byte or one 16-bit word per request. Software loads a 24-bit source pointer, a 24-bit destination pointer, a transfer count and a control word through a write-only register port. After that, every request taken while the engine is enabled and idle runs one transfer. A transfer is a read phase at the source pointer, then a write phase that sends the captured data to the destination pointer. Each phase uses a valid/ready handshake on a shared memory bus.

When the write phase has been accepted, each pointer moves by its own rule: hold, increment or decrement. The step is 1 for bytes and 2 for words. The count then goes down by one. When the count reaches zero, the enable bit clears. If the interrupt enable is set, an interrupt request is raised and stays high until software acknowledges it. A count of zero gives the longest run, 2^CNT_W transfers.

The sequencer has four states, each named for what it does:

- `ST_IDLE` waits for a request. It goes to `ST_READ` when `req` is high and the enable bit is set.
- `ST_READ` presents the source pointer. It goes to `ST_WRITE` on `bus_ready`.
- `ST_WRITE` presents the destination pointer and the data. It goes to `ST_STEP` on `bus_ready`.
- `ST_STEP` updates the pointers and the count, and always returns to `ST_IDLE`.

Top module: `xfer_engine`

## Requirements
- R1: `cpu_wr` loads the register chosen by `cpu_sel` on the next clock edge, but only while the sequencer is in `ST_IDLE`. The encoding is 0 = source pointer, 1 = destination pointer, 2 = count (low CNT_W bits), 3 = control, 4 = interrupt acknowledge. A write made while a transfer is in progress is ignored.
- R2: A request taken in `ST_IDLE` while the enable bit is set starts exactly one transfer. The transfer is a read phase (`bus_write`=0) at the source pointer, then a write phase (`bus_write`=1) at the destination pointer. Requests are ignored while the enable bit is clear or while a transfer is in progress.
- R3: In either phase, `bus_valid`, `bus_addr`, `bus_write` and `bus_wdata` stay unchanged until the cycle in which `bus_ready` is high.
- R4: Control bit 2 selects the size: 0 = byte, 1 = word. `bus_word` shows the selected size. In byte mode the write data is the low 8 bits of the read data, zero-extended; in word mode it is all 16 bits.
- R5: Control bits 4:3 set the rule for the source pointer and bits 6:5 the rule for the destination pointer: 00 or 11 = hold, 01 = increment, 10 = decrement. The step is 1 for bytes and 2 for words. Pointers wrap modulo 2^24 and are updated once, after the write phase is accepted.
- R6: The count goes down by one per completed transfer. When it reaches zero, the enable bit (control bit 0, shown on `run_o`) clears and the engine stops.
- R7: A count of zero gives 2^CNT_W transfers.
- R8: If control bit 1 (interrupt enable) is set when the count reaches zero, `irq_o` rises in the same cycle that `run_o` falls. It stays high until a write to select 4 or to the control register.
- R9: After reset, `run_o`, `irq_o` and `bus_valid` are low, and all pointer, count and control registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_sel | input | 3 | Register select |
| cpu_wdata | input | ADDR_W | Register write data |
| req | input | 1 | Transfer request |
| bus_valid | output | 1 | Bus phase valid |
| bus_write | output | 1 | 1 = write phase, 0 = read phase |
| bus_word | output | 1 | 1 = word access, 0 = byte access |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Write data |
| bus_ready | input | 1 | Bus phase accepted |
| bus_rdata | input | DATA_W | Read data |
| run_o | output | 1 | Enable bit |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check four things on every cycle:

- a bus phase holds steady while it is stalled;
- every write phase directly follows an accepted read phase;
- the count drops by exactly one at each `ST_STEP`;
- the interrupt rises only together with the fall of the enable bit, and no bus phase starts while the engine is disabled.

Only the bench scenarios can show the address arithmetic. This covers each hold, increment and decrement rule at both sizes, including wrap past zero and past the top of the address space. The same holds for the number of transfers a count produces (including the zero-count maximum), for writes and requests dropped in mid-transfer, and for the interrupt acknowledge paths.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_STEP  = 2'd3
    } xfer_state_e;

    // Pointer update rule
    localparam logic [1:0] AM_HOLD  = 2'b00;
    localparam logic [1:0] AM_INC   = 2'b01;
    localparam logic [1:0] AM_DEC   = 2'b10;
    localparam logic [1:0] AM_HOLD2 = 2'b11;

    // Register selects
    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_SRC  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_DST  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_CNT  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd3;
    localparam logic [SEL_W-1:0] SEL_ACK  = 3'd4;

    // Control word, bit 0 at the bottom
    typedef struct packed {
        logic [1:0] dst_mode;   // [6:5]
        logic [1:0] src_mode;   // [4:3]
        logic       word;       // [2]
        logic       irq_en;     // [1]
        logic       run;        // [0]
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/xfer_addr_step.sv
module xfer_addr_step
    import xfer_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [1:0]        mode,
    input  logic              word,
    output logic [ADDR_W-1:0] nxt
);

    logic [ADDR_W-1:0] step;

    always_comb begin
        step = word ? ADDR_W'(2) : ADDR_W'(1);
        unique case (mode)
            AM_INC:   nxt = cur + step;
            AM_DEC:   nxt = cur - step;
            AM_HOLD:  nxt = cur;
            AM_HOLD2: nxt = cur;
        endcase
    end

endmodule

// File: rtl/xfer_regs.sv
module xfer_regs
    import xfer_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [SEL_W-1:0]  cpu_sel,
    input  logic [ADDR_W-1:0] cpu_wdata,
    input  logic              idle,
    input  logic              step,
    input  logic [ADDR_W-1:0] src_next,
    input  logic [ADDR_W-1:0] dst_next,
    output logic [ADDR_W-1:0] src,
    output logic [ADDR_W-1:0] dst,
    output logic [CNT_W-1:0]  count,
    output ctrl_t             ctrl,
    output logic              irq
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic last;
    assign last = (count == CNT_ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src   <= '0;
            dst   <= '0;
            count <= '0;
            ctrl  <= '0;
            irq   <= 1'b0;
        end else if (step) begin
            src   <= src_next;
            dst   <= dst_next;
            count <= count - CNT_ONE;
            if (last) begin
                ctrl.run <= 1'b0;
                if (ctrl.irq_en) begin
                    irq <= 1'b1;
                end
            end
        end else if (cpu_wr && idle) begin
            case (cpu_sel)
                SEL_SRC:  src   <= cpu_wdata;
                SEL_DST:  dst   <= cpu_wdata;
                SEL_CNT:  count <= cpu_wdata[CNT_W-1:0];
                SEL_CTRL: begin
                    ctrl <= ctrl_t'(cpu_wdata[CTRL_W-1:0]);
                    irq  <= 1'b0;
                end
                SEL_ACK:  irq   <= 1'b0;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/xfer_fsm.sv
module xfer_fsm
    import xfer_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              run,
    input  logic              word,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              idle,
    output logic              step
);

    localparam int BYTE_W = DATA_W / 2;

    xfer_state_e state, state_nx;
    logic [DATA_W-1:0] data_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Captured read data, narrowed for byte transfers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (state == ST_READ && bus_ready) begin
            data_q <= word ? bus_rdata
                           : {{(DATA_W-BYTE_W){1'b0}}, bus_rdata[BYTE_W-1:0]};
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req && run) state_nx = ST_READ;
            ST_READ:  if (bus_ready)  state_nx = ST_WRITE;
            ST_WRITE: if (bus_ready)  state_nx = ST_STEP;
            ST_STEP:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        idle      = 1'b0;
        step      = 1'b0;
        unique case (state)
            ST_IDLE: idle = 1'b1;
            ST_READ: begin
                bus_valid = 1'b1;
                bus_addr  = src;
            end
            ST_WRITE: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = dst;
                bus_wdata = data_q;
            end
            ST_STEP: step = 1'b1;
        endcase
    end

endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
    import xfer_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [2:0]        cpu_sel,
    input  logic [ADDR_W-1:0] cpu_wdata,
    input  logic              req,
    output logic              bus_valid,
    output logic              bus_write,
    output logic              bus_word,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              run_o,
    output logic              irq_o
);

    localparam int NPTR = 2;   // 0 = source, 1 = destination

    logic [ADDR_W-1:0] src_w, dst_w;
    logic [CNT_W-1:0]  count_w;
    ctrl_t             ctrl_w;
    logic              idle_w, step_w;
    logic [ADDR_W-1:0] ptr_cur [NPTR];
    logic [ADDR_W-1:0] ptr_nxt [NPTR];
    logic [1:0]        ptr_mode [NPTR];

    assign ptr_cur[0]  = src_w;
    assign ptr_cur[1]  = dst_w;
    assign ptr_mode[0] = ctrl_w.src_mode;
    assign ptr_mode[1] = ctrl_w.dst_mode;

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        xfer_addr_step #(.ADDR_W(ADDR_W)) u_step (
            .cur  (ptr_cur[g]),
            .mode (ptr_mode[g]),
            .word (ctrl_w.word),
            .nxt  (ptr_nxt[g])
        );
    end

    xfer_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr    (cpu_wr),
        .cpu_sel   (cpu_sel),
        .cpu_wdata (cpu_wdata),
        .idle      (idle_w),
        .step      (step_w),
        .src_next  (ptr_nxt[0]),
        .dst_next  (ptr_nxt[1]),
        .src       (src_w),
        .dst       (dst_w),
        .count     (count_w),
        .ctrl      (ctrl_w),
        .irq       (irq_o)
    );

    xfer_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .run       (ctrl_w.run),
        .word      (ctrl_w.word),
        .src       (src_w),
        .dst       (dst_w),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .idle      (idle_w),
        .step      (step_w)
    );

    assign run_o    = ctrl_w.run;
    assign bus_word = ctrl_w.word;

endmodule

// File: rtl/xfer_engine_chk.sv
module xfer_engine_chk #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ready,
    input logic              run_o,
    input logic              irq_o,
    input logic              idle_w,
    input logic              step_w,
    input logic [CNT_W-1:0]  count_w
);

    p_hold_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr)
                                 && $stable(bus_write) && $stable(bus_wdata));

    p_read_then_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_valid && bus_write) |-> $past(bus_valid && !bus_write && bus_ready));

    p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idle_w && !run_o |=> !bus_valid);

    p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step_w |=> count_w == $past(count_w) - CNT_W'(1));

    p_stop_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_o) |-> $past(step_w || cpu_wr));

    p_irq_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $fell(run_o));

endmodule

bind xfer_engine xfer_engine_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_wr    (cpu_wr),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .run_o     (run_o),
    .irq_o     (irq_o),
    .idle_w    (idle_w),
    .step_w    (step_w),
    .count_w   (count_w)
);

// File: tb/xfer_engine_test.sv
module xfer_engine_test;

    localparam int AW = 24;
    localparam int CW = 10;   // short counter so the zero-count run stays brief
    localparam int DW = 16;

    typedef struct packed {
        logic [6:0]  ctrl;
        logic [23:0] src;
        logic [23:0] dst;
        logic [15:0] cnt;
        logic [23:0] erd;   // expected last read address
        logic [23:0] ewr;   // expected last write address
        logic [15:0] n;     // expected transfers
        logic [3:0]  stall;
    } vec_t;

    // ctrl: [0] run [1] irq_en [2] word [4:3] src rule [6:5] dst rule
    localparam vec_t VEC [5] = '{
        '{7'h2B, 24'h001000, 24'h002000, 16'd4, 24'h001003, 24'h002003, 16'd4, 4'd0},
        '{7'h4D, 24'h000100, 24'h000800, 16'd3, 24'h000104, 24'h0007FC, 16'd3, 4'd1},
        '{7'h43, 24'h123456, 24'h000010, 16'd5, 24'h123456, 24'h00000C, 16'd5, 4'd2},
        '{7'h75, 24'h000002, 24'h400000, 16'd3, 24'hFFFFFE, 24'h400000, 16'd3, 4'd0},
        '{7'h2F, 24'hFFFFFE, 24'h000000, 16'd2, 24'h000000, 24'h000002, 16'd2, 4'd1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_wr = 1'b0;
    logic [2:0]    cpu_sel = '0;
    logic [AW-1:0] cpu_wdata = '0;
    logic          req = 1'b0;
    logic          bus_valid, bus_write, bus_word;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_ready = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic          run_o, irq_o;

    int n_chk = 0;
    int n_err = 0;
    int stall = 0;
    int wcnt = 0;
    int n_rd = 0;
    int n_wr = 0;
    logic [AW-1:0] last_rd = '0;
    logic [AW-1:0] last_wr = '0;
    logic [DW-1:0] last_wd = '0;

    always #5 clk = ~clk;

    xfer_engine #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
        .cpu_wdata(cpu_wdata), .req(req), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_word(bus_word), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .run_o(run_o), .irq_o(irq_o)
    );

    function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
        return a[15:0] ^ 16'hA5C3;
    endfunction

    assign bus_rdata = mem_val(bus_addr);

    // Memory responder with programmable wait states; logs accepted phases
    always @(negedge clk) begin
        if (!rst_n || !bus_valid) begin
            bus_ready = 1'b0;
            wcnt = 0;
        end else if (wcnt >= stall) begin
            bus_ready = 1'b1;
            wcnt = 0;
            if (bus_write) begin
                n_wr++;
                last_wr = bus_addr;
                last_wd = bus_wdata;
            end else begin
                n_rd++;
                last_rd = bus_addr;
            end
        end else begin
            bus_ready = 1'b0;
            wcnt++;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [AW-1:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_sel = sel; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_to_stop();
        @(negedge clk);
        req = 1'b1;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            #1;
            if (!run_o && !bus_valid) break;
        end
        req = 1'b0;
        idle_cycles(2);
        #1;
    endtask

    task automatic pulse_req();
        @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int base;
        idle_cycles(3);
        #1;
        // R9: reset state
        check("R9 run after reset", run_o, 0);
        check("R9 irq after reset", irq_o, 0);
        check("R9 bus idle after reset", bus_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: registers reset to zero -> first transfer at address 0; R7 zero count
        wr(3'd3, 24'h000001);
        pulse_req();
        idle_cycles(8);
        #1;
        check("R9 reset source ptr", last_rd, 0);
        check("R9 reset dest ptr", last_wr, 0);
        check("R7 still running after one", run_o, 1);
        run_to_stop();
        check("R7 zero count length", n_wr, 1 << CW);

        // R2: request ignored while disabled
        base = n_rd;
        pulse_req();
        idle_cycles(6);
        #1;
        check("R2 request while disabled", n_rd - base, 0);

        // Vector table: R4 R5 R6 R8
        for (int v = 0; v < 5; v++) begin
            wr(3'd4, 24'h0);
            wr(3'd0, VEC[v].src);
            wr(3'd1, VEC[v].dst);
            wr(3'd2, {8'h0, VEC[v].cnt});
            stall = int'(VEC[v].stall);
            base = n_wr;
            wr(3'd3, {17'h0, VEC[v].ctrl});
            run_to_stop();
            check($sformatf("R6 transfers v%0d", v), n_wr - base, VEC[v].n);
            check($sformatf("R5 last read v%0d", v), last_rd, VEC[v].erd);
            check($sformatf("R5 last write v%0d", v), last_wr, VEC[v].ewr);
            check($sformatf("R4 data v%0d", v), last_wd,
                  VEC[v].ctrl[2] ? mem_val(VEC[v].erd) : {8'h0, mem_val(VEC[v].erd)[7:0]});
            check($sformatf("R4 size v%0d", v), bus_word, VEC[v].ctrl[2]);
            check($sformatf("R8 irq v%0d", v), irq_o, VEC[v].ctrl[1]);
            check($sformatf("R6 stopped v%0d", v), run_o, 0);
        end
        stall = 0;

        // R8: irq held, then acknowledged by select 4
        idle_cycles(10);
        #1;
        check("R8 irq held", irq_o, 1);
        wr(3'd4, 24'h0);
        #1;
        check("R8 ack clears irq", irq_o, 0);

        // R8: control write clears irq
        wr(3'd2, 24'd1);
        wr(3'd3, 24'h000003);
        run_to_stop();
        check("R8 irq single", irq_o, 1);
        check("R6 single stop", run_o, 0);
        wr(3'd3, 24'h000002);
        #1;
        check("R8 ctrl write clears irq", irq_o, 0);

        // R2/R1: one request = one transfer; busy request and write dropped
        wr(3'd0, 24'h000500);
        wr(3'd1, 24'h000600);
        wr(3'd2, 24'd5);
        wr(3'd3, 24'h000029);
        stall = 3;
        base = n_rd;
        @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        req = 1'b1; cpu_wr = 1'b1; cpu_sel = 3'd0; cpu_wdata = 24'h00ABCD;
        @(negedge clk);
        req = 1'b0; cpu_wr = 1'b0;
        idle_cycles(20);
        #1;
        check("R2 one transfer per request", n_rd - base, 1);
        check("R2 read at source", last_rd, 24'h000500);
        check("R2 write at dest", last_wr, 24'h000600);
        stall = 0;
        pulse_req();
        idle_cycles(8);
        #1;
        check("R1 busy write ignored", last_rd, 24'h000501);
        check("R6 still running", run_o, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule